// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Target

This block is the device end of a three-wire serial EEPROM, holding 1024 bits in on-chip flops. A host selects the part with `cs` and clocks bits in on `di` with `sk`. The block answers on `do_o`, and `do_oe` tells the pad when to drive. An organization pin chooses between 64 words of 16 bits and 128 bytes of 8 bits over the same storage. The block decodes seven commands: read, word erase, word write, enable writes, disable writes, erase everything and write everything. Reads continue across consecutive addresses, and writes are guarded by a protect latch.

All pins are sampled on the system clock `clk`. A rising edge of `sk` is seen on the first `clk` edge that finds `sk` high after it was low. The serial pins have no valid/ready handshake. The host paces every transfer with `sk`, which is the only back-pressure: a bit moves only when the host supplies a rising edge. While a programming cycle runs, the block refuses to decode commands, and it shows this on `do_o` as a busy level. The programming time is a count of `PROG_CYCLES` system clocks.

Top module: `eep_serial_target`

## Requirements
- R1: After reset, `do_oe` is 0, writes are disabled and every storage bit reads as 1.
- R2: A command is a 1 start bit, a 2-bit opcode and an address, each sent MSB first. Opcode 10 is read, 01 is write, 11 is erase and 00 selects the special group. The address has 6 bits when `org_x16`=1 and 7 bits when it is 0. Zeros on `di` before the start bit are ignored.
- R3: A read drives `do_oe`=1 with `do_o`=0 on the `sk` rise that samples the last address bit. Each following rise presents one data bit, MSB first.
- R4: With `cs` still high, a read continues into the next address with no extra zero bit. After the last address it wraps to 0.
- R5: With `org_x16`=0, byte address A maps to word A>>1. Bit 0 of A set selects bits 15:8, and clear selects bits 7:0.
- R6: In the special group, the two most significant address bits select the operation: 11 enables writes, 00 disables them, 10 erases all storage, and 01 writes the following data field to every word or byte.
- R7: While writes are disabled, write, erase, erase-all and write-all change nothing and start no busy period. Reads work whether writes are enabled or disabled.
- R8: Write and write-all take a 16-bit (x16) or 8-bit (x8) data field, MSB first. Erase and erase-all set their target to all ones. Programming starts on the falling edge of `cs` after a complete, enabled command.
- R9: Lowering `cs` drops any partly received command and sets `do_oe` to 0.
- R10: After programming starts, `do_oe`=1 whenever `cs` is high. `do_o` is 0 for `PROG_CYCLES` clocks and 1 after that.
- R11: While the ready level is shown, a 1 on `di` at an `sk` rise sets `do_oe` to 0, and so does a `cs` fall. While busy, `sk` rises are ignored and the status level stays on.
- R12: `di` is sampled and `do_o`/`do_oe` change only on the clock edge that sees an `sk` rise or `cs` fall, or when the busy period ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| org_x16 | input | 1 | 1 selects 16-bit words, 0 selects bytes |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out or ready/busy level |
| do_oe | output | 1 | Drive enable for the data-out pad |

## Verification
A wrong internal state shows at the ports within one serial bit. A miscounted address shift drops or adds the dummy zero, or moves the word by one bit on the very next rise. A lost protect latch shows as a busy level on the next `cs` high that should not be there, and a wrong byte select corrupts the first byte read back. A busy counter that is off shows as a ready level a clock early or late. For that reason the bench's behavioural model compares `do_o` and `do_oe` on every clock, so an error is reported in the cycle where it first appears.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_OPC, PH_ADDR, PH_DATA, PH_READ, PH_HOLD
  } phase_e;

  typedef enum logic [2:0] {
    PK_NONE, PK_WRITE, PK_ERASE, PK_ERAL, PK_WRAL
  } pend_e;

  localparam logic [1:0] OPC_SPECIAL = 2'b00;
  localparam logic [1:0] OPC_WRITE   = 2'b01;
  localparam logic [1:0] OPC_READ    = 2'b10;
  localparam logic [1:0] OPC_ERASE   = 2'b11;

  localparam logic [1:0] SUB_WDIS = 2'b00;
  localparam logic [1:0] SUB_WRAL = 2'b01;
  localparam logic [1:0] SUB_ERAL = 2'b10;
  localparam logic [1:0] SUB_WEN  = 2'b11;
endpackage

// File: rtl/eep_edge.sv
module eep_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sk,
  input  logic cs,
  output logic sk_rise,
  output logic cs_fall
);
  logic sk_q, cs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sk_q <= 1'b0;
      cs_q <= 1'b0;
    end else begin
      sk_q <= sk;
      cs_q <= cs;
    end
  end

  assign sk_rise = sk & ~sk_q;
  assign cs_fall = ~cs & cs_q;
endmodule

// File: rtl/eep_busy_timer.sv
module eep_busy_timer #(
  parameter int PROG_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int TW = $clog2(PROG_CYCLES + 1);
  logic [TW-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n)             left <= '0;
    else if (start)         left <= TW'(PROG_CYCLES);
    else if (left != '0)    left <= left - TW'(1);
  end

  assign busy = (left != '0);
endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int WORDS = 64,
  parameter int WIDTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     wr_all,
  input  logic [$clog2(WORDS)-1:0] wr_idx,
  input  logic [WIDTH-1:0]         wr_data,
  input  logic [WIDTH-1:0]         wr_mask,
  input  logic [$clog2(WORDS)-1:0] rd_idx,
  output logic [WIDTH-1:0]         rd_word
);
  logic [WIDTH-1:0] mem [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)
        mem[g] <= '1;
      else if (wr_en && (wr_all || wr_idx == g[$clog2(WORDS)-1:0]))
        mem[g] <= (mem[g] & ~wr_mask) | (wr_data & wr_mask);
    end
  end

  assign rd_word = mem[rd_idx];
endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
  import eep_pkg::*;
#(
  parameter int WORDS = 64,
  parameter int WIDTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     org_x16,
  input  logic                     cs,
  input  logic                     di,
  input  logic                     sk_rise,
  input  logic                     cs_fall,
  input  logic                     busy,
  input  logic [WIDTH-1:0]         rd_word,
  output logic [$clog2(WORDS)-1:0] rd_idx,
  output logic                     prog_start,
  output logic                     wr_all,
  output logic [$clog2(WORDS)-1:0] wr_idx,
  output logic [WIDTH-1:0]         wr_data,
  output logic [WIDTH-1:0]         wr_mask,
  output logic                     do_o,
  output logic                     do_oe
);
  localparam int WAW  = $clog2(WORDS);
  localparam int AW8  = WAW + 1;
  localparam int HALF = WIDTH / 2;
  localparam int BW   = $clog2(WIDTH);
  localparam int CW   = $clog2(WIDTH + 1);

  phase_e           ph;
  pend_e            pk;
  logic [CW-1:0]    cnt;
  logic [1:0]       opc;
  logic [AW8-1:0]   adr;
  logic [WIDTH-1:0] dat;
  logic             wen;
  logic [AW8-1:0]   ra;
  logic [BW-1:0]    rb;
  logic             do_q, oe_q, stat_pend;

  logic [CW-1:0]    aw_m1, dw_m1;
  logic [AW8-1:0]   adr_nx, ra_start, ra_inc;
  logic [WAW-1:0]   ra_w;
  logic [1:0]       sub;
  logic [WIDTH-1:0] unit;
  logic [BW-1:0]    bsel;
  logic             parse_ok, stat_show;

  // field lengths depend on organization
  assign aw_m1  = org_x16 ? CW'(WAW - 1) : CW'(WAW);
  assign dw_m1  = org_x16 ? CW'(WIDTH - 1) : CW'(HALF - 1);
  assign adr_nx = {adr[AW8-2:0], di};
  assign sub    = org_x16 ? adr_nx[WAW-1:WAW-2] : adr_nx[WAW:WAW-1];

  // read pointer in words (x16) or bytes (x8), wrapping at the top
  assign ra_start = org_x16 ? {1'b0, adr_nx[WAW-1:0]} : adr_nx;
  assign ra_w     = ra[WAW-1:0] + WAW'(1);
  assign ra_inc   = org_x16 ? {1'b0, ra_w} : ra + AW8'(1);
  assign rd_idx   = org_x16 ? ra[WAW-1:0] : ra[AW8-1:1];
  assign unit     = org_x16 ? rd_word
                  : {{HALF{1'b0}}, (ra[0] ? rd_word[WIDTH-1:HALF] : rd_word[HALF-1:0])};
  assign bsel     = dw_m1[BW-1:0] - rb;

  // write port toward the array
  assign prog_start = cs_fall && (ph == PH_HOLD) && (pk != PK_NONE) && wen;
  assign wr_all     = (pk == PK_ERAL) || (pk == PK_WRAL);
  assign wr_idx     = org_x16 ? adr[WAW-1:0] : adr[AW8-1:1];
  always_comb begin
    if (pk == PK_ERASE || pk == PK_ERAL) wr_data = '1;
    else if (org_x16)                    wr_data = dat;
    else                                 wr_data = {dat[HALF-1:0], dat[HALF-1:0]};
    if (org_x16 || wr_all) wr_mask = '1;
    else if (adr[0])       wr_mask = {{HALF{1'b1}}, {HALF{1'b0}}};
    else                   wr_mask = {{HALF{1'b0}}, {HALF{1'b1}}};
  end

  assign parse_ok  = cs && sk_rise && !stat_pend && !busy;
  assign stat_show = stat_pend && cs;
  assign do_oe     = stat_show || oe_q;
  assign do_o      = stat_show ? ~busy : do_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= PH_IDLE;  pk <= PK_NONE;  cnt <= '0;  opc <= '0;
      adr <= '0;  dat <= '0;  wen <= 1'b0;  ra <= '0;  rb <= '0;
      do_q <= 1'b0;  oe_q <= 1'b0;  stat_pend <= 1'b0;
    end else if (cs_fall) begin
      if (prog_start)  stat_pend <= 1'b1;
      else if (!busy)  stat_pend <= 1'b0;
      ph   <= PH_IDLE;
      pk   <= PK_NONE;
      oe_q <= 1'b0;
      do_q <= 1'b0;
    end else if (cs && sk_rise && stat_pend) begin
      if (!busy && di) stat_pend <= 1'b0;
    end else if (parse_ok) begin
      unique case (ph)
        PH_IDLE: if (di) begin
          ph  <= PH_OPC;
          pk  <= PK_NONE;
          cnt <= '0;
        end
        PH_OPC: begin
          opc <= {opc[0], di};
          if (cnt == CW'(1)) begin ph <= PH_ADDR; cnt <= '0; end
          else cnt <= cnt + CW'(1);
        end
        PH_ADDR: begin
          adr <= adr_nx;
          if (cnt == aw_m1) begin
            cnt <= '0;
            case (opc)
              OPC_READ: begin
                ph <= PH_READ;  ra <= ra_start;  rb <= '0;
                oe_q <= 1'b1;   do_q <= 1'b0;
              end
              OPC_WRITE: begin ph <= PH_DATA; pk <= PK_WRITE; end
              OPC_ERASE: begin ph <= PH_HOLD; pk <= PK_ERASE; end
              default: begin
                case (sub)
                  SUB_WEN:  begin ph <= PH_HOLD; wen <= 1'b1; end
                  SUB_WDIS: begin ph <= PH_HOLD; wen <= 1'b0; end
                  SUB_ERAL: begin ph <= PH_HOLD; pk <= PK_ERAL; end
                  default:  begin ph <= PH_DATA; pk <= PK_WRAL; end
                endcase
              end
            endcase
          end else cnt <= cnt + CW'(1);
        end
        PH_DATA: begin
          dat <= {dat[WIDTH-2:0], di};
          if (cnt == dw_m1) ph <= PH_HOLD;
          else cnt <= cnt + CW'(1);
        end
        PH_READ: begin
          do_q <= unit[bsel];
          if (rb == dw_m1[BW-1:0]) begin rb <= '0; ra <= ra_inc; end
          else rb <= rb + BW'(1);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/eep_serial_target.sv
module eep_serial_target #(
  parameter int WORDS       = 64,
  parameter int WIDTH       = 16,
  parameter int PROG_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic org_x16,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic do_o,
  output logic do_oe
);
  localparam int WAW = $clog2(WORDS);

  logic             sk_rise, cs_fall, busy, prog_start, wr_all;
  logic [WAW-1:0]   rd_idx, wr_idx;
  logic [WIDTH-1:0] rd_word, wr_data, wr_mask;

  eep_edge u_edge (
    .clk(clk), .rst_n(rst_n), .sk(sk), .cs(cs),
    .sk_rise(sk_rise), .cs_fall(cs_fall)
  );

  eep_busy_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(prog_start), .busy(busy)
  );

  eep_store #(.WORDS(WORDS), .WIDTH(WIDTH)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(prog_start), .wr_all(wr_all),
    .wr_idx(wr_idx), .wr_data(wr_data), .wr_mask(wr_mask),
    .rd_idx(rd_idx), .rd_word(rd_word)
  );

  eep_ctrl #(.WORDS(WORDS), .WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .org_x16(org_x16), .cs(cs), .di(di),
    .sk_rise(sk_rise), .cs_fall(cs_fall), .busy(busy), .rd_word(rd_word),
    .rd_idx(rd_idx), .prog_start(prog_start), .wr_all(wr_all),
    .wr_idx(wr_idx), .wr_data(wr_data), .wr_mask(wr_mask),
    .do_o(do_o), .do_oe(do_oe)
  );
endmodule

// File: rtl/eep_serial_target_chk.sv
module eep_serial_target_chk (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic sk,
  input logic do_o,
  input logic do_oe,
  input logic busy,
  input logic prog_start
);
  // R9: a deselected part never drives the pad
  a_r9_cs_low_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs && $past(!cs)) |-> !do_oe);

  // R10: programming start is followed by a busy period
  a_r10_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> busy);

  // R10: a driven pad during busy shows the low level
  a_r10_busy_low: assert property (@(posedge clk) disable iff (!rst_n)
    (do_oe && busy) |-> !do_o);

  // R11: status cannot be released while busy
  a_r11_hold_status_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cs) |-> do_oe);

  // R12: without an sk rise, cs change or busy change, outputs hold
  a_r12_quiet_without_sk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && $past(cs) && $stable(busy) && !($past(sk, 1) && !$past(sk, 2)))
      |-> ($stable(do_o) && $stable(do_oe)));
endmodule

bind eep_serial_target eep_serial_target_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .do_o(do_o), .do_oe(do_oe),
  .busy(busy), .prog_start(prog_start)
);

// File: tb/eep_serial_target_tb_top.sv
module eep_serial_target_tb_top;
  localparam int PROG = 40;

  logic clk = 1'b0, rst_n = 1'b0, org_x16 = 1'b1, cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_o, do_oe;
  int tests = 0, fails = 0;
  int rdq[$];
  bit dummy_q, dummy_oe, last_oe;

  always #2 clk = ~clk;

  eep_serial_target #(.WORDS(64), .WIDTH(16), .PROG_CYCLES(PROG)) dut_i (
    .clk(clk), .rst_n(rst_n), .org_x16(org_x16), .cs(cs), .sk(sk), .di(di),
    .do_o(do_o), .do_oe(do_oe)
  );

  // ---------------- behavioural reference model ----------------
  int m_mem[64];
  int m_wen, m_busy, m_stat, m_ph, m_n, m_hdr, m_dat, m_kind, m_addr;
  int m_ra, m_rb, m_oe, m_do, m_skp, m_csp;

  function automatic void m_put(int ba, int v, int x16);
    if (x16) m_mem[ba] = v & 'hFFFF;
    else if (ba & 1) m_mem[ba >> 1] = (m_mem[ba >> 1] & 'h00FF) | ((v & 'hFF) << 8);
    else             m_mem[ba >> 1] = (m_mem[ba >> 1] & 'hFF00) | (v & 'hFF);
  endfunction

  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 'hFFFF;
      m_wen = 0; m_busy = 0; m_stat = 0; m_ph = 0; m_oe = 0; m_do = 0;
      m_skp = 0; m_csp = 0; m_kind = 0;
    end else begin
      int aw, dw, was_busy, eoe, edo, x16;
      x16 = org_x16; aw = x16 ? 6 : 7; dw = x16 ? 16 : 8;
      was_busy = (m_busy > 0);
      if (m_busy > 0) m_busy--;
      if (m_csp && !cs) begin
        if (m_ph == 5 && m_kind != 0 && m_wen) begin
          case (m_kind)
            1: m_put(m_addr, m_dat, x16);
            2: m_put(m_addr, 'hFFFF, x16);
            3: foreach (m_mem[i]) m_mem[i] = 'hFFFF;
            default: foreach (m_mem[i]) m_mem[i] = x16 ? (m_dat & 'hFFFF)
                                                  : ((m_dat & 'hFF) * 257);
          endcase
          m_busy = PROG; m_stat = 1;
        end else if (!was_busy) m_stat = 0;
        m_ph = 0; m_oe = 0; m_do = 0; m_kind = 0;
      end else if (cs && sk && !m_skp) begin
        if (m_stat || was_busy) begin
          if (m_stat && !was_busy && di) m_stat = 0;
        end else begin
          case (m_ph)
            0: if (di) begin m_ph = 1; m_n = 0; m_hdr = 0; m_kind = 0; end
            1: begin
              m_hdr = (m_hdr << 1) | di; m_n++;
              if (m_n == 2 + aw) begin
                int op; op = m_hdr >> aw; m_addr = m_hdr & ((1 << aw) - 1);
                m_n = 0; m_dat = 0;
                if (op == 2) begin m_ph = 4; m_ra = m_addr; m_rb = 0; m_oe = 1; m_do = 0; end
                else if (op == 1) begin m_ph = 3; m_kind = 1; end
                else if (op == 3) begin m_ph = 5; m_kind = 2; end
                else case (m_addr >> (aw - 2))
                  3: begin m_wen = 1; m_ph = 5; end
                  0: begin m_wen = 0; m_ph = 5; end
                  2: begin m_kind = 3; m_ph = 5; end
                  default: begin m_kind = 4; m_ph = 3; end
                endcase
              end
            end
            3: begin m_dat = (m_dat << 1) | di; m_n++; if (m_n == dw) m_ph = 5; end
            4: begin
              int u;
              u = x16 ? m_mem[m_ra] : ((m_mem[m_ra >> 1] >> ((m_ra & 1) ? 8 : 0)) & 'hFF);
              m_do = (u >> (dw - 1 - m_rb)) & 1;
              m_rb++;
              if (m_rb == dw) begin m_rb = 0; m_ra = (m_ra + 1) % (x16 ? 64 : 128); end
            end
            default: ;
          endcase
        end
      end
      m_skp = sk; m_csp = cs;
      eoe = (m_stat && cs) ? 1 : m_oe;
      edo = (m_stat && cs) ? (m_busy == 0) : m_do;
      if (cs || m_oe) begin
        tests++;
        if (do_oe !== eoe[0] || (eoe != 0 && do_o !== edo[0])) begin
          fails++;
          $display("FAIL R12 per-clock model: actual oe=%0b do=%0b expected oe=%0d do=%0d",
                   do_oe, do_o, eoe, edo);
        end
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clk_bit(input bit b, output bit q);
    @(negedge clk); di = b; sk = 1'b0;
    @(negedge clk); sk = 1'b1;
    @(posedge clk); #1; q = do_o; last_oe = do_oe;
  endtask

  task automatic send(input int v, input int n);
    bit q;
    for (int i = n - 1; i >= 0; i--) clk_bit(bit'((v >> i) & 1), q);
  endtask

  task automatic cs_up();
    @(negedge clk); cs = 1'b1; sk = 1'b0;
  endtask

  task automatic cs_down();
    @(negedge clk); cs = 1'b0; sk = 1'b0; di = 1'b0;
    @(negedge clk);
  endtask

  function automatic int awid();
    return org_x16 ? 6 : 7;
  endfunction

  task automatic cmd(input int op, input int a);
    cs_up(); send(1, 1); send(op, 2); send(a, awid());
  endtask

  task automatic finish_prog(input string req);
    cs_up();
    repeat (PROG + 3) @(negedge clk);
    chk({req, " ready level"}, {31'd0, do_oe} * 2 + {31'd0, do_o}, 3);
    cs_down();
  endtask

  task automatic wr(input int a, input int v, input string req);
    cmd(1, a); send(v, org_x16 ? 16 : 8); cs_down(); finish_prog(req);
  endtask

  task automatic rd(input int a, input int n);
    bit q;
    int dw, w;
    dw = org_x16 ? 16 : 8;
    cs_up(); send(1, 1); send(2, 2);
    for (int i = awid() - 1; i >= 0; i--) clk_bit(bit'((a >> i) & 1), q);
    dummy_q = q; dummy_oe = last_oe;
    rdq.delete();
    for (int k = 0; k < n; k++) begin
      w = 0;
      for (int b = 0; b < dw; b++) begin clk_bit(1'b0, q); w = (w << 1) | int'(q); end
      rdq.push_back(w);
    end
    cs_down();
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    bit q;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset do_oe", {31'd0, do_oe}, 0);

    rd(5, 1);
    chk("R3 dummy bit value", {31'd0, dummy_q}, 0);
    chk("R3 dummy bit drives", {31'd0, dummy_oe}, 1);
    chk("R1 erased word after reset", rdq[0], 'hFFFF);

    // writes while disabled
    cmd(1, 5); send('h1234, 16); cs_down();
    cs_up(); repeat (3) @(negedge clk);
    chk("R7 no busy while disabled", {31'd0, do_oe}, 0);
    cs_down();
    rd(5, 1);
    chk("R7 protected word unchanged", rdq[0], 'hFFFF);

    // enable, then write with status walk
    cmd(0, 'b110000); cs_down();
    cmd(1, 5); send('hA5C3, 16); cs_down();
    cs_up(); repeat (2) @(negedge clk);
    chk("R10 busy level", {31'd0, do_oe} * 2 + {31'd0, do_o}, 2);
    clk_bit(1'b1, q);
    chk("R11 no release while busy", {31'd0, last_oe}, 1);
    repeat (PROG) @(negedge clk);
    chk("R10 ready level", {31'd0, do_o}, 1);
    clk_bit(1'b1, q);
    chk("R11 release by shifted one", {31'd0, last_oe}, 0);
    cs_down();
    rd(5, 1);
    chk("R8 written word", rdq[0], 'hA5C3);

    // sequential read with wrap
    wr(0, 'h0F0F, "R8");
    wr(63, 'h1111, "R8");
    rd(63, 3);
    chk("R4 first word", rdq[0], 'h1111);
    chk("R4 wrap to zero", rdq[1], 'h0F0F);
    chk("R4 next after wrap", rdq[2], 'hFFFF);

    // leading zeros before start bit
    cs_up(); send(0, 3);
    send(1, 1); send(2, 2); send(0, 6); send(0, 16);
    cs_down();
    rd(0, 1);
    chk("R2 plain read of word 0", rdq[0], 'h0F0F);

    // abort a partial write
    cs_up(); send(1, 1); send(1, 2); send(5, 6); send('hFF, 8);
    cs_down();
    chk("R9 hiz after abort", {31'd0, do_oe}, 0);
    cs_up(); repeat (3) @(negedge clk);
    chk("R9 aborted write started nothing", {31'd0, do_oe}, 0);
    cs_down();
    rd(5, 1);
    chk("R9 word kept", rdq[0], 'hA5C3);

    // erase, write-all, erase-all
    cmd(3, 5); cs_down(); finish_prog("R8");
    rd(5, 1);
    chk("R8 erase sets ones", rdq[0], 'hFFFF);
    cmd(0, 'b010000); send('h3C3C, 16); cs_down(); finish_prog("R6");
    rd(10, 1);
    chk("R6 write-all", rdq[0], 'h3C3C);
    cmd(0, 'b100000); cs_down(); finish_prog("R6");
    rd(40, 1);
    chk("R6 erase-all", rdq[0], 'hFFFF);

    // byte organization
    @(negedge clk); org_x16 = 1'b0;
    wr(11, 'h7E, "R5");
    wr(0, 'h12, "R5");
    rd(11, 1);
    chk("R5 high byte", rdq[0], 'h7E);
    rd(10, 1);
    chk("R5 low byte untouched", rdq[0], 'hFF);
    rd(127, 2);
    chk("R4 byte wrap last", rdq[0], 'hFF);
    chk("R4 byte wrap first", rdq[1], 'h12);
    @(negedge clk); org_x16 = 1'b1;
    rd(5, 1);
    chk("R5 word view of bytes", rdq[0], 'h7EFF);

    // disable writes again
    cmd(0, 'b000000); cs_down();
    cmd(1, 5); send('h0000, 16); cs_down();
    cs_up(); repeat (3) @(negedge clk);
    chk("R6 disable leaves no busy", {31'd0, do_oe}, 0);
    cs_down();
    rd(5, 1);
    chk("R7 read while disabled", rdq[0], 'h7EFF);

    repeat (4) @(negedge clk);
    summary();
  end
endmodule